// File: doc/BRIEF.md
# PC-Indexed Dynamic Branch Predictor

This block keeps a small history table that guesses the direction of conditional branches. The low bits of a branch's program counter select one entry directly. There is no tag, so two branches whose addresses share those low bits also share an entry. The fetch stage presents a lookup address and gets a taken guess back in the same cycle. When a conditional branch resolves later in the pipeline, the resolving stage presents that branch's address, a qualifier saying it is a conditional branch, and the real direction. The addressed entry is then trained at the next clock edge.

A parameter picks the entry type. In last-outcome mode each entry is one bit that stores the most recent direction. In saturating mode each entry is a two-bit counter, so one surprise does not flip the guess. The block also counts the resolved branches it sees and how many of them the table would have guessed wrongly. These two counters let loop behaviour be measured at the ports.

Top module: `bp_predictor`

## Requirements
- R1: After reset, every entry guesses not taken. Each saturating counter holds 1 (weakly not taken), each last-outcome bit holds 0, and both statistics counters read 0.
- R2: The entry is selected by lkp_pc[3:0] for a lookup and by upd_pc[3:0] for an update, which gives 16 entries. Addresses that differ only above bit 3 use the same entry.
- R3: In last-outcome mode (HIST = HIST_LAST), after an update the entry's guess equals the direction of that update.
- R4: When upd_valid is 0, no entry and no counter changes, whatever upd_pc and upd_taken carry.
- R5: In saturating mode (HIST = HIST_SAT2), an update adds one to the counter when taken and subtracts one when not taken. The counter stays at 3 on a further taken update and at 0 on a further not-taken update.
- R6: In saturating mode, the guess is taken exactly when the counter is 2 or 3. A single taken update from reset therefore flips the guess to taken.
- R7: When a lookup and an update select the same entry in the same cycle, the lookup returns the value from before the update. The new value is seen from the next cycle on.
- R8: stat_branches goes up by one for each cycle with upd_valid high.
- R9: stat_mispredicts goes up by one for each valid update whose direction differs from the addressed entry's guess before that update.
- R10: An update changes only the entry it selects. All other entries keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | PC_W | Address of the instruction being fetched |
| lkp_taken | output | 1 | Combinational taken guess for lkp_pc |
| upd_valid | input | 1 | A conditional branch resolves this cycle |
| upd_pc | input | PC_W | Address of the resolving branch |
| upd_taken | input | 1 | Actual direction of the resolving branch |
| stat_branches | output | CNT_W | Number of resolved branches seen |
| stat_mispredicts | output | CNT_W | Number of resolved branches the table guessed wrongly |

## Verification
The hardest case to reach is the same-cycle collision. The fetch lookup and the resolving update must select the same entry in one cycle, and the entry must be in a state where the update changes the guess. The bench sets this up on an untouched entry of the last-outcome instance. It drives the lookup and a taken update together and samples the guess before the edge, then again after it. Saturation at both ends is reached by a walked vector table of repeated updates on one entry. Those updates use varying upper address bits so that aliasing is exercised along the way.

// File: rtl/bp_pkg.sv
package bp_pkg;
    // Entry organisation of the history table
    typedef enum logic [0:0] {
        HIST_LAST = 1'b0,   // one bit, last direction
        HIST_SAT2 = 1'b1    // two-bit saturating counter
    } bp_hist_e;
endpackage

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
    import bp_pkg::*;
#(
    parameter bp_hist_e HIST  = HIST_SAT2,
    parameter int       CTR_W = 2
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             taken,
    output logic [CTR_W-1:0] nxt,
    output logic             pred
);
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_MIN = '0;
    localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

    // guess is the top bit in both organisations
    assign pred = cur[CTR_W-1];

    generate
        if (HIST == HIST_SAT2) begin : g_sat
            always_comb begin
                nxt = cur;
                if (taken && (cur != CTR_MAX)) begin
                    nxt = cur + CTR_ONE;
                end else if (!taken && (cur != CTR_MIN)) begin
                    nxt = cur - CTR_ONE;
                end
            end
        end else begin : g_last
            always_comb begin
                nxt = {CTR_W{taken}};
            end
        end
    endgenerate
endmodule

// File: rtl/bp_stats.sv
module bp_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             wrong,
    output logic [CNT_W-1:0] branches,
    output logic [CNT_W-1:0] mispredicts
);
    typedef struct packed {
        logic [CNT_W-1:0] br;
        logic [CNT_W-1:0] mis;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (valid) begin
            stat_d.br = stat_q.br + CNT_W'(1);
            if (wrong) begin
                stat_d.mis = stat_q.mis + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign branches    = stat_q.br;
    assign mispredicts = stat_q.mis;

    // R8: each resolved branch adds exactly one
    p_branch_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> branches == $past(branches) + CNT_W'(1));

    // R4: idle cycles keep both counters
    p_idle_stats_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(branches) && $stable(mispredicts)));

    // R9: correct guesses leave the miss count alone
    p_hit_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wrong) |=> $stable(mispredicts));
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
    import bp_pkg::*;
#(
    parameter int       PC_W  = 32,
    parameter int       IDX_W = 4,
    parameter int       CNT_W = 16,
    parameter bp_hist_e HIST  = HIST_SAT2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lkp_pc,
    output logic             lkp_taken,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    output logic [CNT_W-1:0] stat_branches,
    output logic [CNT_W-1:0] stat_mispredicts
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int CTR_W   = (HIST == HIST_SAT2) ? 2 : 1;
    localparam logic [CTR_W-1:0] RST_VAL = (HIST == HIST_SAT2) ? CTR_W'(1) : '0;

    typedef struct packed {
        logic [ENTRIES-1:0][CTR_W-1:0] tbl;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]              lkp_idx, upd_idx;
    logic [ENTRIES-1:0][CTR_W-1:0] nxt_vec;
    logic [ENTRIES-1:0]            pred_vec;
    logic                          upd_pred;
    logic                          unused_pc_hi;

    assign lkp_idx      = lkp_pc[IDX_W-1:0];
    assign upd_idx      = upd_pc[IDX_W-1:0];
    assign unused_pc_hi = ^{lkp_pc[PC_W-1:IDX_W], upd_pc[PC_W-1:IDX_W]};

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            bp_ctr_next #(
                .HIST  (HIST),
                .CTR_W (CTR_W)
            ) u_next (
                .cur   (state_q.tbl[e]),
                .taken (upd_taken),
                .nxt   (nxt_vec[e]),
                .pred  (pred_vec[e])
            );
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (upd_valid) begin
            state_d.tbl[upd_idx] = nxt_vec[upd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= {ENTRIES{RST_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    // lookups read the registered table: old value on a same-cycle collision
    assign lkp_taken = pred_vec[lkp_idx];
    assign upd_pred  = pred_vec[upd_idx];

    bp_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (upd_valid),
        .wrong       (upd_pred != upd_taken),
        .branches    (stat_branches),
        .mispredicts (stat_mispredicts)
    );

    // R4: no qualifier, no table change
    p_table_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(state_q));

    generate
        if (HIST == HIST_LAST) begin : g_chk_last
            // R3: entry holds the last direction
            p_last_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> state_q.tbl[$past(upd_idx)] == {CTR_W{$past(upd_taken)}});
        end else begin : g_chk_sat
            // R5: saturation at the top
            p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_taken && state_q.tbl[upd_idx] == {CTR_W{1'b1}})
                |=> state_q.tbl[$past(upd_idx)] == {CTR_W{1'b1}});
            // R5: saturation at the bottom
            p_sat_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && !upd_taken && state_q.tbl[upd_idx] == '0)
                |=> state_q.tbl[$past(upd_idx)] == '0);
            // R6: a taken update from weakly not taken flips the guess
            p_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_taken && state_q.tbl[upd_idx] == CTR_W'(1))
                |=> pred_vec[$past(upd_idx)]);
        end
    endgenerate
endmodule

// File: tb/bp_predictor_tb.sv
`timescale 1ns/1ps
module bp_predictor_tb;
    import bp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lkp_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        taken2, taken1;
    logic [15:0] br2, mis2, br1, mis1;

    int checks = 0;
    int errors = 0;
    int m2 [16];
    int m1 [16];
    int exp_br = 0, exp_mis2 = 0, exp_mis1 = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bp_predictor #(.HIST(HIST_SAT2)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(taken2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .stat_branches(br2), .stat_mispredicts(mis2));

    bp_predictor #(.HIST(HIST_LAST)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(taken1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .stat_branches(br1), .stat_mispredicts(mis1));

    // {taken, expected saturating guess after the update}, all on entry 5
    localparam logic [1:0] VEC [9] = '{2'b11, 2'b11, 2'b11, 2'b01, 2'b00,
                                       2'b00, 2'b00, 2'b10, 2'b11};

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_upd(int idx, bit t);
        exp_br++;
        if ((m2[idx] >= 2) != t) exp_mis2++;
        if ((m1[idx] != 0) != t) exp_mis1++;
        if (t && m2[idx] < 3) m2[idx]++;
        if (!t && m2[idx] > 0) m2[idx]--;
        m1[idx] = t;
    endtask

    task automatic upd(logic [31:0] pc, bit t);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        model_upd(int'(pc[3:0]), t);
    endtask

    task automatic look(logic [31:0] pc);
        lkp_pc = pc;
        #0.5;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int b0, m20, m10;
        for (int i = 0; i < 16; i++) begin m2[i] = 1; m1[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            look(32'h0000_2000 | i);
            check("R1 sat guess", taken2, 0);
            check("R1 last guess", taken1, 0);
        end
        check("R1 stat_branches", br2, 0);
        check("R1 stat_mispredicts", mis2, 0);

        // R5 R6 R3 R2: vector walk on entry 5 with aliasing upper bits
        for (int v = 0; v < 9; v++) begin
            upd(32'h0000_1005 + (v << 8), VEC[v][1]);
            look(32'h0000_ABC5 + (v << 12));
            check("R5/R6 R2 sat guess", taken2, VEC[v][0]);
            check("R3 R2 last guess", taken1, VEC[v][1]);
        end

        // R10: neighbours untouched
        look(32'h6); check("R10 entry6 sat", taken2, 0);
        look(32'h4); check("R10 entry4 last", taken1, 0);

        // R4: unqualified traffic ignored
        @(negedge clk);
        upd_pc = 32'h7; upd_taken = 1'b1; upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        look(32'h7);
        check("R4 sat guess", taken2, 0);
        check("R4 last guess", taken1, 0);
        check("R4 stat_branches", br2, exp_br);

        // R7: collision on entry 9
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h9; upd_taken = 1'b1;
        look(32'h0000_0F09);
        check("R7 old last value", taken1, 0);
        check("R7 old sat value", taken2, 0);
        @(negedge clk);
        upd_valid = 1'b0;
        model_upd(9, 1'b1);
        look(32'h0000_0F09);
        check("R7 new last value", taken1, 1);
        check("R7 new sat value", taken2, 1);

        // R9 R8: two passes of a ten-iteration loop on entry 4
        b0 = br2; m20 = mis2; m10 = mis1;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 10; k++)
                upd(32'h0040_0104, k != 9);
        check("R8 loop branches", int'(br2) - b0, 20);
        check("R9 loop misses sat", int'(mis2) - m20, 3);
        check("R9 loop misses last", int'(mis1) - m10, 4);

        check("R8 total sat", br2, exp_br);
        check("R8 total last", br1, exp_br);
        check("R9 total sat", mis2, exp_mis2);
        check("R9 total last", mis1, exp_mis1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule